// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block runs the translation walk that follows a TLB miss. It accepts a page number, an access kind (read or write), the requester's privilege (user or supervisor) and a flag saying whether the miss came from instruction prefetch. It fetches the directory entry, then the table entry, over a single-outstanding 32-bit memory port. It checks the present bits and the combined permissions, and sets the accessed and dirty bits in memory where they change. It then either hands a fill record to the TLB or reports a page fault with an error code.

A prefetch miss is refused at once and no memory is touched. The later demand access performs the walk and takes any fault. The directory base comes in on a plain input that a control register outside the block holds. The TLB array and fault delivery live elsewhere.

Top module: `pgw_walker`

## Requirements
- R1: The first memory access of a walk is a read at `pd_base + 4 * req_vpn[19:10]` (linear address bits 31:22).
- R2: The second access is a read at `{dir_entry[31:12], 12'h000} + 4 * req_vpn[9:0]` (linear address bits 21:12).
- R3: A request with `req_prefetch = 1` gives `done` in the next cycle with `fault = 0` and `tlb_fill = 0`, and makes no memory access.
- R4: A directory or table entry with bit 0 (present) clear ends the walk with `fault = 1` and `fault_code[0] = 0`, and nothing is written to memory.
- R5: The page counts as user only when bit 2 is set in both entries. A user access to a supervisor page, or a user write to a user page whose bit 1 is not set in both entries, faults with `fault_code[0] = 1` and no memory write.
- R6: On any fault, `fault_code[1]` is the write flag and `fault_code[2]` is the user flag of the request.
- R7: After the checks pass, a directory entry with bit 5 (accessed) clear is written back with bit 5 set. A directory entry that already has bit 5 set is not written. The directory write comes before any table write.
- R8: The table entry gets bit 5 set, and on a write access bit 6 (dirty) set. It is written back only if its value changes. `tlb_dirty` shows bit 6 of the resulting entry.
- R9: On success `tlb_fill` and `done` pulse together. `tlb_vpn` is the request page number, `tlb_frame` is table entry bits 31:12 and `tlb_user` is the request's user flag.
- R10: `tlb_wr` is the AND of both entries' bit 1 for a user page, and 1 for a supervisor page. A supervisor write to a read-only user page does not fault.
- R11: While `mem_valid` is high and `mem_ready` low, `mem_addr`, `mem_we` and `mem_wdata` hold their values.
- R12: Requests are taken only while `req_ready` is high (idle), and `mem_valid` is never high at that time. `done`, `fault` and `tlb_fill` last one cycle per walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Miss request strobe |
| req_ready | output | 1 | High while idle; a request is taken on `req_valid && req_ready` |
| req_vpn | input | 20 | Linear address bits 31:12 |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Requester runs at user privilege |
| req_prefetch | input | 1 | Miss raised by instruction prefetch |
| pd_base | input | 32 | Page directory base address |
| mem_valid | output | 1 | Memory request pending |
| mem_ready | input | 1 | Memory completes the pending request this cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Entry address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| done | output | 1 | Walk finished (any outcome) |
| fault | output | 1 | Walk ended in a page fault |
| fault_code | output | 3 | {user, write, protection} |
| tlb_fill | output | 1 | Fill record valid |
| tlb_vpn | output | 20 | Page number to tag |
| tlb_frame | output | 20 | Physical frame number |
| tlb_user | output | 1 | Entry belongs to user privilege |
| tlb_wr | output | 1 | Combined writable attribute |
| tlb_dirty | output | 1 | Dirty state of the page |

## Verification
Some properties are checked every cycle. These are the address of the directory read, the immediate refusal of prefetch misses, the idle-only acceptance, the one-cycle fault pulse, the stability of a stalled memory request, the accessed bit on every written entry, and the access bits of the fault code. The bench scenarios cover the rest: the permission combinations, where a supervisor page, a read-only user page and a supervisor write each give a different outcome. They also cover the exact write-back values and their suppression when nothing changes, the table entry address, and the fill fields. These scenarios run under memory latencies of zero to two wait cycles.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    localparam int VA_W    = 32;
    localparam int OFF_W   = 12;
    localparam int VPN_W   = VA_W - OFF_W;
    localparam int IDX_W   = VPN_W / 2;
    localparam int ENT_SH  = 2;
    localparam int ECODE_W = 3;

    localparam int F_PRES  = 0;
    localparam int F_RW    = 1;
    localparam int F_US    = 2;
    localparam int F_ACC   = 5;
    localparam int F_DIRTY = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_RD,
        ST_TBL_RD,
        ST_DIR_WB,
        ST_TBL_WB
    } walk_st_e;

    typedef struct packed {
        walk_st_e             st;
        logic [VPN_W-1:0]     vpn;
        logic                 wr;
        logic                 usr;
        logic [VA_W-1:0]      dent;
        logic [VA_W-1:0]      tent;
        logic                 tent_wb;
        logic                 page_wr;
        logic                 done;
        logic                 fault;
        logic [ECODE_W-1:0]   code;
        logic                 fill;
    } walk_s;
endpackage

// File: rtl/pgw_entry_addr.sv
module pgw_entry_addr
    import pgw_pkg::*;
(
    input  logic [VA_W-1:0]  base,
    input  logic [VPN_W-1:0] vpn,
    input  logic [VPN_W-1:0] tbl_frame,
    output logic [VA_W-1:0]  dir_addr,
    output logic [VA_W-1:0]  tbl_addr
);
    logic [VA_W-1:0] dir_off;
    logic [VA_W-1:0] tbl_off;

    always_comb begin
        dir_off = '0;
        tbl_off = '0;
        dir_off[IDX_W+ENT_SH-1:ENT_SH] = vpn[VPN_W-1:VPN_W-IDX_W];
        tbl_off[IDX_W+ENT_SH-1:ENT_SH] = vpn[IDX_W-1:0];
    end

    assign dir_addr = base + dir_off;
    assign tbl_addr = {tbl_frame, {OFF_W{1'b0}}} + tbl_off;
endmodule

// File: rtl/pgw_perm.sv
module pgw_perm (
    input  logic dir_rw,
    input  logic dir_us,
    input  logic tbl_rw,
    input  logic tbl_us,
    input  logic acc_user,
    input  logic acc_write,
    output logic page_wr,
    output logic viol
);
    logic page_user;

    assign page_user = dir_us & tbl_us;
    // supervisor pages ignore the R/W bits
    assign page_wr   = page_user ? (dir_rw & tbl_rw) : 1'b1;
    assign viol      = acc_user & (~page_user | (acc_write & ~page_wr));
endmodule

// File: rtl/pgw_flag_upd.sv
module pgw_flag_upd
    import pgw_pkg::*;
(
    input  logic [VA_W-1:0] dir_in,
    input  logic [VA_W-1:0] tbl_in,
    input  logic            wr,
    output logic [VA_W-1:0] dir_out,
    output logic            dir_chg,
    output logic [VA_W-1:0] tbl_out,
    output logic            tbl_chg
);
    always_comb begin
        dir_out          = dir_in;
        dir_out[F_ACC]   = 1'b1;
        tbl_out          = tbl_in;
        tbl_out[F_ACC]   = 1'b1;
        if (wr) begin
            tbl_out[F_DIRTY] = 1'b1;
        end
    end

    assign dir_chg = (dir_out != dir_in);
    assign tbl_chg = (tbl_out != tbl_in);
endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
    import pgw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VPN_W-1:0]   req_vpn,
    input  logic               req_write,
    input  logic               req_user,
    input  logic               req_prefetch,
    input  logic [VA_W-1:0]    pd_base,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic               mem_we,
    output logic [VA_W-1:0]    mem_addr,
    output logic [VA_W-1:0]    mem_wdata,
    input  logic [VA_W-1:0]    mem_rdata,
    output logic               done,
    output logic               fault,
    output logic [ECODE_W-1:0] fault_code,
    output logic               tlb_fill,
    output logic [VPN_W-1:0]   tlb_vpn,
    output logic [VPN_W-1:0]   tlb_frame,
    output logic               tlb_user,
    output logic               tlb_wr,
    output logic               tlb_dirty
);
    walk_s walk_q, walk_d;

    logic [VA_W-1:0] dir_addr, tbl_addr;
    logic [VA_W-1:0] dent_new, tent_new;
    logic            dir_chg, tbl_chg;
    logic            perm_wr, perm_viol;

    pgw_entry_addr u_addr (
        .base      (pd_base),
        .vpn       (walk_q.vpn),
        .tbl_frame (walk_q.dent[VA_W-1:OFF_W]),
        .dir_addr  (dir_addr),
        .tbl_addr  (tbl_addr)
    );

    pgw_perm u_perm (
        .dir_rw    (walk_q.dent[F_RW]),
        .dir_us    (walk_q.dent[F_US]),
        .tbl_rw    (mem_rdata[F_RW]),
        .tbl_us    (mem_rdata[F_US]),
        .acc_user  (walk_q.usr),
        .acc_write (walk_q.wr),
        .page_wr   (perm_wr),
        .viol      (perm_viol)
    );

    pgw_flag_upd u_flags (
        .dir_in  (walk_q.dent),
        .tbl_in  (mem_rdata),
        .wr      (walk_q.wr),
        .dir_out (dent_new),
        .dir_chg (dir_chg),
        .tbl_out (tent_new),
        .tbl_chg (tbl_chg)
    );

    always_comb begin
        walk_d       = walk_q;
        walk_d.done  = 1'b0;
        walk_d.fault = 1'b0;
        walk_d.fill  = 1'b0;
        unique case (walk_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    walk_d.vpn = req_vpn;
                    walk_d.wr  = req_write;
                    walk_d.usr = req_user;
                    if (req_prefetch) begin
                        walk_d.done = 1'b1;
                    end else begin
                        walk_d.st = ST_DIR_RD;
                    end
                end
            end
            ST_DIR_RD: begin
                if (mem_ready) begin
                    walk_d.dent = mem_rdata;
                    if (!mem_rdata[F_PRES]) begin
                        walk_d.st    = ST_IDLE;
                        walk_d.done  = 1'b1;
                        walk_d.fault = 1'b1;
                        walk_d.code  = {walk_q.usr, walk_q.wr, 1'b0};
                    end else begin
                        walk_d.st = ST_TBL_RD;
                    end
                end
            end
            ST_TBL_RD: begin
                if (mem_ready) begin
                    if (!mem_rdata[F_PRES] || perm_viol) begin
                        walk_d.st    = ST_IDLE;
                        walk_d.done  = 1'b1;
                        walk_d.fault = 1'b1;
                        walk_d.code  = {walk_q.usr, walk_q.wr, mem_rdata[F_PRES]};
                    end else begin
                        walk_d.tent    = tent_new;
                        walk_d.tent_wb = tbl_chg;
                        walk_d.page_wr = perm_wr;
                        if (dir_chg) begin
                            walk_d.st = ST_DIR_WB;
                        end else if (tbl_chg) begin
                            walk_d.st = ST_TBL_WB;
                        end else begin
                            walk_d.st   = ST_IDLE;
                            walk_d.done = 1'b1;
                            walk_d.fill = 1'b1;
                        end
                    end
                end
            end
            ST_DIR_WB: begin
                if (mem_ready) begin
                    if (walk_q.tent_wb) begin
                        walk_d.st = ST_TBL_WB;
                    end else begin
                        walk_d.st   = ST_IDLE;
                        walk_d.done = 1'b1;
                        walk_d.fill = 1'b1;
                    end
                end
            end
            ST_TBL_WB: begin
                if (mem_ready) begin
                    walk_d.st   = ST_IDLE;
                    walk_d.done = 1'b1;
                    walk_d.fill = 1'b1;
                end
            end
            default: walk_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_q <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    always_comb begin
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (walk_q.st)
            ST_DIR_RD: begin
                mem_valid = 1'b1;
                mem_addr  = dir_addr;
            end
            ST_TBL_RD: begin
                mem_valid = 1'b1;
                mem_addr  = tbl_addr;
            end
            ST_DIR_WB: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dir_addr;
                mem_wdata = dent_new;
            end
            ST_TBL_WB: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = tbl_addr;
                mem_wdata = walk_q.tent;
            end
            default: ;
        endcase
    end

    assign req_ready  = (walk_q.st == ST_IDLE);
    assign done       = walk_q.done;
    assign fault      = walk_q.fault;
    assign fault_code = walk_q.code;
    assign tlb_fill   = walk_q.fill;
    assign tlb_vpn    = walk_q.vpn;
    assign tlb_frame  = walk_q.tent[VA_W-1:OFF_W];
    assign tlb_user   = walk_q.usr;
    assign tlb_wr     = walk_q.page_wr;
    assign tlb_dirty  = walk_q.tent[F_DIRTY];
endmodule

// File: rtl/pgw_walker_chk.sv
module pgw_walker_chk
    import pgw_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [VPN_W-1:0]   req_vpn,
    input logic               req_write,
    input logic               req_user,
    input logic               req_prefetch,
    input logic [VA_W-1:0]    pd_base,
    input logic               mem_valid,
    input logic               mem_ready,
    input logic               mem_we,
    input logic [VA_W-1:0]    mem_addr,
    input logic [VA_W-1:0]    mem_wdata,
    input logic               done,
    input logic               fault,
    input logic [1:0]         fault_acc,
    input logic               tlb_fill,
    input logic               tlb_user
);
    logic cap_w, cap_u;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_w <= 1'b0;
            cap_u <= 1'b0;
        end else if (req_valid && req_ready) begin
            cap_w <= req_write;
            cap_u <= req_user;
        end
    end

    a_r1_dir_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_prefetch) |=>
            (mem_valid && !mem_we &&
             mem_addr == $past(pd_base) + {{(VA_W-IDX_W-ENT_SH){1'b0}}, $past(req_vpn[VPN_W-1:VPN_W-IDX_W]), {ENT_SH{1'b0}}}));

    a_r3_prefetch_nowalk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_prefetch) |=> (done && !fault && !tlb_fill && !mem_valid));

    a_r3_fault_ends: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (done && !tlb_fill));

    a_r6_code_bits: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_acc == {cap_u, cap_w}));

    a_r8_wb_accessed: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we) |-> mem_wdata[F_ACC]);

    a_r9_fill_user: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_fill |-> (done && tlb_user == cap_u));

    a_r11_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=>
            (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    a_r12_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !req_ready);

    a_r12_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);
endmodule

bind pgw_walker pgw_walker_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_vpn      (req_vpn),
    .req_write    (req_write),
    .req_user     (req_user),
    .req_prefetch (req_prefetch),
    .pd_base      (pd_base),
    .mem_valid    (mem_valid),
    .mem_ready    (mem_ready),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .done         (done),
    .fault        (fault),
    .fault_acc    (fault_code[2:1]),
    .tlb_fill     (tlb_fill),
    .tlb_user     (tlb_user)
);

// File: tb/pgw_walker_test.sv
module pgw_walker_test;
    localparam int CLK_P = 10;
    localparam logic [31:0] PDB = 32'h0010_0000;

    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic        usr;
        logic [31:0] pde;
        logic [31:0] pte;
        logic        x_fault;
        logic [2:0]  x_code;
        logic        x_pde_wb;
        logic        x_pte_wb;
        logic [31:0] x_pte_data;
        logic        x_wr;
        logic        x_dirty;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{32'h0040_3ABC, 1'b0, 1'b1, 32'h0020_0027, 32'h1234_5027, 1'b0, 3'd0, 1'b0, 1'b0, 32'h0,           1'b1, 1'b0},
        '{32'hFFC0_1123, 1'b1, 1'b1, 32'h0020_0007, 32'h1234_5007, 1'b0, 3'd0, 1'b1, 1'b1, 32'h1234_5067, 1'b1, 1'b1},
        '{32'h0040_3ABC, 1'b0, 1'b1, 32'h0020_0005, 32'h1234_5027, 1'b0, 3'd0, 1'b1, 1'b0, 32'h0,           1'b0, 1'b0},
        '{32'h0040_3ABC, 1'b1, 1'b1, 32'h0020_0025, 32'h1234_5027, 1'b1, 3'd7, 1'b0, 1'b0, 32'h0,           1'b0, 1'b0},
        '{32'h0040_3ABC, 1'b0, 1'b1, 32'h0020_0023, 32'h1234_5027, 1'b1, 3'd5, 1'b0, 1'b0, 32'h0,           1'b0, 1'b0},
        '{32'h0040_3ABC, 1'b1, 1'b0, 32'h0020_0021, 32'h1234_5001, 1'b0, 3'd0, 1'b0, 1'b1, 32'h1234_5061, 1'b1, 1'b1},
        '{32'h0040_3ABC, 1'b0, 1'b0, 32'h0020_0000, 32'h1234_5027, 1'b1, 3'd0, 1'b0, 1'b0, 32'h0,           1'b0, 1'b0},
        '{32'h0040_3ABC, 1'b1, 1'b1, 32'h0020_0027, 32'h1234_5066, 1'b1, 3'd6, 1'b0, 1'b0, 32'h0,           1'b0, 1'b0},
        '{32'h0040_3ABC, 1'b1, 1'b0, 32'h0020_0027, 32'h1234_5065, 1'b0, 3'd0, 1'b0, 1'b0, 32'h0,           1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_vpn = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        req_prefetch = 1'b0;
    logic        mem_valid, mem_we;
    logic        mem_ready;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata;
    logic        done, fault, tlb_fill, tlb_user, tlb_wr, tlb_dirty;
    logic [2:0]  fault_code;
    logic [19:0] tlb_vpn, tlb_frame;

    pgw_walker uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
        .req_write(req_write), .req_user(req_user), .req_prefetch(req_prefetch),
        .pd_base(PDB),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .fault(fault), .fault_code(fault_code),
        .tlb_fill(tlb_fill), .tlb_vpn(tlb_vpn), .tlb_frame(tlb_frame),
        .tlb_user(tlb_user), .tlb_wr(tlb_wr), .tlb_dirty(tlb_dirty)
    );

    always #(CLK_P/2) clk = ~clk;

    // memory model state (written by the bench sequence)
    logic [31:0] cur_pde = '0, cur_pte = '0, pde_addr = '0, pte_addr = '0;
    int          lat = 0;
    // memory model counters (written by the model only)
    int          n_txn = 0, n_bad = 0, n_pde_wr = 0, n_pte_wr = 0, wait_cnt = 0;
    logic [31:0] pde_wd = '0, pte_wd = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_ready <= 1'b0;
            mem_rdata <= '0;
            wait_cnt  <= 0;
        end else if (mem_ready) begin
            mem_ready <= 1'b0;
            n_txn <= n_txn + 1;
            if (mem_we) begin
                if (mem_addr == pde_addr) begin
                    n_pde_wr <= n_pde_wr + 1;
                    pde_wd   <= mem_wdata;
                end else if (mem_addr == pte_addr) begin
                    n_pte_wr <= n_pte_wr + 1;
                    pte_wd   <= mem_wdata;
                end else begin
                    n_bad <= n_bad + 1;
                end
            end
        end else if (mem_valid) begin
            if (wait_cnt >= lat) begin
                wait_cnt  <= 0;
                mem_ready <= 1'b1;
                if (!mem_we && mem_addr == pde_addr)      mem_rdata <= cur_pde;
                else if (!mem_we && mem_addr == pte_addr) mem_rdata <= cur_pte;
                else begin
                    mem_rdata <= 32'hBAD0_0BAD;
                    if (!mem_we) n_bad <= n_bad + 1;
                end
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    int n_chk = 0, n_fail = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int t0, b0, dw0, tw0;
        bit seen;
        repeat (3) @(negedge clk);
        // reset state (R12)
        chk("R12 reset req_ready", 32'(req_ready), 32'd1);
        chk("R12 reset done", 32'(done), 32'd0);
        chk("R12 reset fault", 32'(fault), 32'd0);
        chk("R12 reset mem_valid", 32'(mem_valid), 32'd0);
        chk("R9 reset tlb_fill", 32'(tlb_fill), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            cur_pde  = v.pde;
            cur_pte  = v.pte;
            pde_addr = PDB + {20'd0, v.va[31:22], 2'b00};
            pte_addr = {v.pde[31:12], 12'h000} + {20'd0, v.va[21:12], 2'b00};
            lat      = i % 3;
            t0 = n_txn; b0 = n_bad; dw0 = n_pde_wr; tw0 = n_pte_wr;
            req_valid = 1'b1; req_vpn = v.va[31:12]; req_write = v.wr;
            req_user = v.usr; req_prefetch = 1'b0;
            @(negedge clk);
            req_valid = 1'b0;
            chk("R12 busy after accept", 32'(req_ready), 32'd0);
            seen = 1'b0;
            for (int c = 0; c < 40; c++) begin
                if (done) begin
                    seen = 1'b1;
                    break;
                end
                @(negedge clk);
            end
            chk("R12 walk completes", 32'(seen), 32'd1);
            chk("R4 R5 fault flag", 32'(fault), 32'(v.x_fault));
            chk("R9 fill flag", 32'(tlb_fill), 32'(!v.x_fault));
            if (v.x_fault) begin
                chk("R4 R5 R6 fault code", 32'(fault_code), 32'(v.x_code));
            end else begin
                chk("R9 tlb_vpn", 32'(tlb_vpn), 32'(v.va[31:12]));
                chk("R9 tlb_frame", 32'(tlb_frame), 32'(v.pte[31:12]));
                chk("R9 tlb_user", 32'(tlb_user), 32'(v.usr));
                chk("R10 tlb_wr", 32'(tlb_wr), 32'(v.x_wr));
                chk("R8 tlb_dirty", 32'(tlb_dirty), 32'(v.x_dirty));
            end
            chk("R1 R2 entry addresses", 32'(n_bad - b0), 32'd0);
            chk("R7 dir writeback count", 32'(n_pde_wr - dw0), 32'(v.x_pde_wb));
            if (v.x_pde_wb) chk("R7 dir writeback data", pde_wd, v.pde | 32'h20);
            chk("R8 table writeback count", 32'(n_pte_wr - tw0), 32'(v.x_pte_wb));
            if (v.x_pte_wb) chk("R8 table writeback data", pte_wd, v.x_pte_data);
            @(negedge clk);
            chk("R12 done pulse", 32'(done), 32'd0);
            chk("R12 transactions", 32'(n_txn - t0),
                32'(1 + (v.pde[0] ? 1 : 0) + 32'(v.x_pde_wb) + 32'(v.x_pte_wb)));
        end

        // prefetch miss: refused at once (R3)
        t0 = n_txn;
        req_valid = 1'b1; req_vpn = 20'h00403; req_write = 1'b0;
        req_user = 1'b1; req_prefetch = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_prefetch = 1'b0;
        chk("R3 prefetch done", 32'(done), 32'd1);
        chk("R3 prefetch no fault", 32'(fault), 32'd0);
        chk("R3 prefetch no fill", 32'(tlb_fill), 32'd0);
        chk("R3 prefetch no mem", 32'(mem_valid), 32'd0);
        repeat (3) @(negedge clk);
        chk("R3 prefetch no txn", 32'(n_txn - t0), 32'd0);
        chk("R12 idle after prefetch", 32'(req_ready), 32'd1);

        finish_run();
    end
endmodule